// File: doc/BRIEF.md
# Software Interrupt Router

This block carries inter-processor software interrupts among up to eight CPUs. A CPU sends one by writing a 32-bit trigger word. The word names one of sixteen software interrupt numbers and selects the set of target CPUs. For every target, and for every interrupt number, the router keeps a bitmap of the CPUs that sent it. A number stays pending at a target while it has senders there.

A target CPU acknowledges a number, and the router returns the number with the sending CPU encoded in the upper bits. Acknowledges from one sender are served one at a time, lowest-numbered sender first. Software can also edit a target's sender bitmap directly, setting bits or clearing them. The router takes one operation per cycle. Arbitration by priority and the bus decoding that produces the request strobes are left to neighbouring logic.

Top module: `sgi_router`

## Requirements
- R1: After reset, no interrupt is pending at any target and `rsp_valid` is low.
- R2: A trigger word carries the interrupt number in bits 9:0, the target filter in bits 25:24 and the target list in bits 23:16. With filter value 0, the number becomes pending at exactly the CPUs whose bit is set in the target list. Pending for target t and number i appears on `pend` bit t*16+i one cycle after the trigger.
- R3: With filter value 1, the trigger reaches every CPU except the writer.
- R4: With filter value 2, the trigger reaches only the writer.
- R5: Filter value 3 is treated as a broadcast to all CPUs. The target list is ignored.
- R6: A trigger whose number is 16 or higher (any of bits 9:4 set) changes no state.
- R7: An acknowledge returns, one cycle later, `rsp_valid` high and `rsp_data` = number | (sender[2:0] << 10). The sender is the lowest-numbered set bit of the target's bitmap for that number, and that bit is cleared.
- R8: The number stays pending at the target until the acknowledge that empties its sender bitmap.
- R9: A clear edit removes the mask bits from the caller's bitmap for the given number. It drops pending only if the bitmap becomes empty.
- R10: A set edit adds the mask bits to the caller's bitmap and marks the number pending, even when the mask is zero.
- R11: An acknowledge of a number whose sender bitmap is empty returns `rsp_err` high with `rsp_data` zero, and it changes no state.
- R12: Only one operation runs per cycle: acknowledge first, then edit, then trigger. A request that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger word strobe |
| trig_cpu | input | 3 | CPU writing the trigger |
| trig_word | input | 32 | Trigger word |
| edit_valid | input | 1 | Bitmap edit strobe |
| edit_set | input | 1 | 1 = set bits, 0 = clear bits |
| edit_cpu | input | 3 | Target CPU whose bitmap is edited |
| edit_id | input | 4 | Interrupt number edited |
| edit_mask | input | 8 | Sender bits to set or clear |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | 3 | Acknowledging CPU |
| ack_id | input | 4 | Number acknowledged |
| rsp_valid | output | 1 | Acknowledge response valid |
| rsp_err | output | 1 | Acknowledge found no sender |
| rsp_data | output | 13 | Number with sender in bits 12:10 |
| pend | output | 128 | Pending flags, bit t*16+i |

## Verification
The four filter codes are each tried with a writer in a different position. This separates a list-driven target set from the exclude-self, self-only and broadcast sets. When two CPUs signal the same target, the order of the returned senders shows that the pick is lowest-first and that pending holds until the last sender is consumed. Edits with partial masks, full masks and a zero mask, together with acknowledges of empty entries, tell apart pending that follows the bitmap and pending that is set without senders. Requests sent together show which operation wins and that the losers leave no trace.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    localparam int CPU_N    = 8;
    localparam int SGI_N    = 16;
    localparam int CPU_W    = $clog2(CPU_N);
    localparam int SGI_W    = $clog2(SGI_N);
    localparam int WORD_W   = 32;
    localparam int ID_W     = 10;
    localparam int SRC_KEEP = 3;
    localparam int RSP_W    = ID_W + SRC_KEEP;
    localparam int LIST_LO  = 16;
    localparam int FILT_LO  = 24;

    typedef logic [CPU_N-1:0] cpu_mask_t;

    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_ALL    = 2'd3
    } filt_e;

    typedef struct packed {
        cpu_mask_t [CPU_N-1:0][SGI_N-1:0] src;
        logic [CPU_N-1:0][SGI_N-1:0]      pend;
        logic                             rsp_valid;
        logic                             rsp_err;
        logic [RSP_W-1:0]                 rsp_data;
    } state_t;
endpackage

// File: rtl/sgi_filter.sv
module sgi_filter
    import sgi_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [CPU_W-1:0]  writer,
    output cpu_mask_t         targets,
    output logic [SGI_W-1:0]  id,
    output logic              id_ok
);
    cpu_mask_t self_bit;
    filt_e     mode;
    logic      unused_bits;

    assign self_bit    = cpu_mask_t'(1) << writer;
    assign mode        = filt_e'(word[FILT_LO +: 2]);
    assign id          = word[SGI_W-1:0];
    assign id_ok       = (word[ID_W-1:SGI_W] == '0);
    assign unused_bits = ^{word[WORD_W-1:FILT_LO+2], word[LIST_LO-1:ID_W]};

    always_comb begin
        case (mode)
            FLT_LIST:   targets = word[LIST_LO +: CPU_N];
            FLT_OTHERS: targets = ~self_bit;
            FLT_SELF:   targets = self_bit;
            default:    targets = '1;
        endcase
    end
endmodule

// File: rtl/sgi_lowest.sv
module sgi_lowest #(
    parameter int W     = 8,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sgi_router.sv
module sgi_router
    import sgi_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   trig_valid,
    input  logic [CPU_W-1:0]       trig_cpu,
    input  logic [WORD_W-1:0]      trig_word,
    input  logic                   edit_valid,
    input  logic                   edit_set,
    input  logic [CPU_W-1:0]       edit_cpu,
    input  logic [SGI_W-1:0]       edit_id,
    input  logic [CPU_N-1:0]       edit_mask,
    input  logic                   ack_valid,
    input  logic [CPU_W-1:0]       ack_cpu,
    input  logic [SGI_W-1:0]       ack_id,
    output logic                   rsp_valid,
    output logic                   rsp_err,
    output logic [RSP_W-1:0]       rsp_data,
    output logic [CPU_N*SGI_N-1:0] pend
);
    state_t st_d, st_q;

    cpu_mask_t          f_targets;
    logic [SGI_W-1:0]   f_id;
    logic               f_id_ok;
    cpu_mask_t          ack_map;
    logic [CPU_W-1:0]   ack_src;
    logic               ack_hit;

    sgi_filter u_filter (
        .word    (trig_word),
        .writer  (trig_cpu),
        .targets (f_targets),
        .id      (f_id),
        .id_ok   (f_id_ok)
    );

    assign ack_map = st_q.src[ack_cpu][ack_id];

    sgi_lowest #(.W(CPU_N), .IDX_W(CPU_W)) u_pick (
        .vec   (ack_map),
        .idx   (ack_src),
        .found (ack_hit)
    );

    always_comb begin
        cpu_mask_t left_d;
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_err   = 1'b0;
        st_d.rsp_data  = '0;
        left_d         = '0;
        if (ack_valid) begin
            st_d.rsp_valid = 1'b1;
            if (!ack_hit) begin
                st_d.rsp_err = 1'b1;
            end else begin
                left_d = ack_map & ~(cpu_mask_t'(1) << ack_src);
                st_d.src[ack_cpu][ack_id] = left_d;
                if (left_d == '0) begin
                    st_d.pend[ack_cpu][ack_id] = 1'b0;
                end
                st_d.rsp_data = {SRC_KEEP'(ack_src), ID_W'(ack_id)};
            end
        end else if (edit_valid) begin
            if (edit_set) begin
                st_d.src[edit_cpu][edit_id]  = st_q.src[edit_cpu][edit_id] | edit_mask;
                st_d.pend[edit_cpu][edit_id] = 1'b1;
            end else begin
                left_d = st_q.src[edit_cpu][edit_id] & ~edit_mask;
                st_d.src[edit_cpu][edit_id] = left_d;
                if (left_d == '0) begin
                    st_d.pend[edit_cpu][edit_id] = 1'b0;
                end
            end
        end else if (trig_valid && f_id_ok) begin
            for (int t = 0; t < CPU_N; t++) begin
                if (f_targets[t]) begin
                    st_d.src[t][f_id][trig_cpu] = 1'b1;
                    st_d.pend[t][f_id]          = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_data  = st_q.rsp_data;
    assign pend      = st_q.pend;

    // R11: an empty acknowledge leaves every bitmap and pending flag as it was
    p_err_keeps_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ($stable(st_q.pend) && $stable(st_q.src)));

    // R11: an error response carries no data
    p_err_zero_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_data == '0));

    // R7: a good response names a number below the implemented count
    p_rsp_id_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> (rsp_data[ID_W-1:SGI_W] == '0));

    // R7: a good acknowledge consumes exactly one sender bit
    p_ack_drops_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |->
            ($countones(st_q.src) + 1 == $countones($past(st_q.src))));

    // R12: a new pending flag needs a winning trigger or set edit
    p_rise_has_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.pend & ~$past(st_q.pend)) != '0) |->
            (!$past(ack_valid) && ($past(trig_valid) || ($past(edit_valid) && $past(edit_set)))));
endmodule

// File: tb/sgi_router_tb.sv
module sgi_router_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         trig_valid;
    logic [2:0]   trig_cpu;
    logic [31:0]  trig_word;
    logic         edit_valid, edit_set;
    logic [2:0]   edit_cpu;
    logic [3:0]   edit_id;
    logic [7:0]   edit_mask;
    logic         ack_valid;
    logic [2:0]   ack_cpu;
    logic [3:0]   ack_id;
    logic         rsp_valid, rsp_err;
    logic [12:0]  rsp_data;
    logic [127:0] pend;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sgi_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .trig_valid(trig_valid), .trig_cpu(trig_cpu), .trig_word(trig_word),
        .edit_valid(edit_valid), .edit_set(edit_set), .edit_cpu(edit_cpu),
        .edit_id(edit_id), .edit_mask(edit_mask),
        .ack_valid(ack_valid), .ack_cpu(ack_cpu), .ack_id(ack_id),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .pend(pend)
    );

    function automatic logic [127:0] pb(input int t, input int i);
        return 128'(1) << (t * 16 + i);
    endfunction

    function automatic logic [31:0] tw(input int filt, input int list, input int id);
        return (32'(filt) << 24) | (32'(list) << 16) | 32'(id);
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        trig_valid = 0; trig_cpu = 0; trig_word = 0;
        edit_valid = 0; edit_set = 0; edit_cpu = 0; edit_id = 0; edit_mask = 0;
        ack_valid = 0; ack_cpu = 0; ack_id = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic trig(input int cpu, input logic [31:0] w);
        trig_valid = 1; trig_cpu = 3'(cpu); trig_word = w;
        tick();
    endtask

    task automatic edit(input bit set, input int cpu, input int id, input int mask);
        edit_valid = 1; edit_set = set; edit_cpu = 3'(cpu); edit_id = 4'(id); edit_mask = 8'(mask);
        tick();
    endtask

    task automatic ack(input string req, input int cpu, input int id, input bit e_err, input int e_data);
        ack_valid = 1; ack_cpu = 3'(cpu); ack_id = 4'(id);
        tick();
        chk({req, " rsp_valid"}, 128'(rsp_valid), 128'(1));
        chk({req, " rsp_err"}, 128'(rsp_err), 128'(e_err));
        chk({req, " rsp_data"}, 128'(rsp_data), 128'(e_data));
    endtask

    task automatic t_reset();
        chk("R1 pend", pend, '0);
        chk("R1 rsp_valid", 128'(rsp_valid), 0);
    endtask

    task automatic t_list();
        trig(1, tw(0, 'hA4, 5));
        chk("R2 list targets", pend, pb(2, 5) | pb(5, 5) | pb(7, 5));
        ack("R7 list ack t2", 2, 5, 0, 'h405);
        ack("R7 list ack t5", 5, 5, 0, 'h405);
        ack("R7 list ack t7", 7, 5, 0, 'h405);
        chk("R2 list drained", pend, '0);
    endtask

    task automatic t_others();
        logic [127:0] e = '0;
        trig(3, tw(1, 'h08, 9));
        for (int t = 0; t < 8; t++) if (t != 3) e |= pb(t, 9);
        chk("R3 others", pend, e);
        for (int t = 0; t < 8; t++) if (t != 3) ack("R3 ack", t, 9, 0, 9 | (3 << 10));
        chk("R3 drained", pend, '0);
    endtask

    task automatic t_self();
        trig(6, tw(2, 'hFF, 0));
        chk("R4 self", pend, pb(6, 0));
        ack("R4 ack", 6, 0, 0, 'h1800);
        chk("R4 drained", pend, '0);
    endtask

    task automatic t_all();
        logic [127:0] e = '0;
        trig(0, tw(3, 'h01, 15));
        for (int t = 0; t < 8; t++) e |= pb(t, 15);
        chk("R5 broadcast", pend, e);
        for (int t = 0; t < 8; t++) ack("R5 ack", t, 15, 0, 15);
        chk("R5 drained", pend, '0);
    endtask

    task automatic t_big_id();
        trig(2, tw(3, 'hFF, 16));
        chk("R6 id 16", pend, '0);
        trig(2, tw(0, 'hFF, 'h205));
        chk("R6 id 0x205", pend, '0);
        ack("R6 no sender", 0, 5, 1, 0);
    endtask

    task automatic t_two_senders();
        trig(4, tw(0, 'h02, 7));
        trig(2, tw(0, 'h02, 7));
        ack("R7 lowest first", 1, 7, 0, 'h807);
        chk("R8 still pending", pend, pb(1, 7));
        ack("R7 second sender", 1, 7, 0, 'h1007);
        chk("R8 cleared", pend, '0);
    endtask

    task automatic t_clear_edit();
        trig(0, tw(0, 'h08, 2));
        trig(5, tw(0, 'h08, 2));
        edit(0, 3, 2, 'h01);
        chk("R9 partial keeps", pend, pb(3, 2));
        ack("R9 remaining", 3, 2, 0, 'h1402);
        chk("R9 drained", pend, '0);
        trig(1, tw(0, 'h08, 2));
        edit(0, 3, 2, 'hFF);
        chk("R9 full clear", pend, '0);
        ack("R9 emptied", 3, 2, 1, 0);
    endtask

    task automatic t_set_edit();
        edit(1, 4, 11, 'h88);
        chk("R10 set pend", pend, pb(4, 11));
        ack("R10 sender 3", 4, 11, 0, 'hC0B);
        ack("R10 sender 7", 4, 11, 0, 'h1C0B);
        chk("R10 drained", pend, '0);
    endtask

    task automatic t_empty_ack();
        ack("R11 empty", 0, 3, 1, 0);
        chk("R11 no change", pend, '0);
        edit(1, 2, 6, 0);
        chk("R10 zero mask sets", pend, pb(2, 6));
        ack("R11 pend no sender", 2, 6, 1, 0);
        chk("R11 pend kept", pend, pb(2, 6));
        edit(0, 2, 6, 0);
        chk("R9 zero mask clears empty", pend, '0);
    endtask

    task automatic t_priority();
        trig_valid = 1; trig_cpu = 0; trig_word = tw(2, 0, 1);
        ack_valid = 1; ack_cpu = 0; ack_id = 1;
        tick();
        chk("R12 ack beats trig err", 128'(rsp_err), 1);
        chk("R12 trig dropped", pend, '0);
        trig_valid = 1; trig_cpu = 0; trig_word = tw(3, 0, 4);
        edit_valid = 1; edit_set = 1; edit_cpu = 5; edit_id = 3; edit_mask = 8'h01;
        tick();
        chk("R12 edit beats trig", pend, pb(5, 3));
        ack("R12 cleanup", 5, 3, 0, 3);
        chk("R12 drained", pend, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_list();
        t_others();
        t_self();
        t_all();
        t_big_id();
        t_two_senders();
        t_clear_edit();
        t_set_edit();
        t_empty_ack();
        t_priority();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule